// File: doc/BRIEF.md
# Posted CAS latency scheduler

This block is the command-timing core of a DDR2-style memory device model. It watches a command port carrying activate, read and write codes. Read and write (column) commands may arrive early, while the activate-to-column delay is still running. Each one is deferred by a programmable additive latency before it counts as issued inside the device. After that, the block produces the strobes that tell the rest of the model when to drive read data and when to capture write data.

The read latency is the additive latency plus the CAS latency. The write latency is one clock less than that. A burst is four beats at two beats per clock, so every data window lasts two clocks and reports which beat pair is live. Pending column commands travel down a shift-register delay line, so several reads and writes can be in flight at once, in order.

Both latencies come from a small register-write port. A monitor counts clocks since the last activate. It raises an error pulse when a column command is issued internally too soon after that activate.

Top module: `pcas_sched`

## Requirements
- R1: After synchronous reset every output is low, the beat indices are 0, the additive latency is 0 and the CAS latency is CL_MIN.
- R2: `cmd` is decoded as 0 = idle, 1 = activate, 2 = read, 3 = write. A read or write is accepted on any clock, including one right after an activate. Idle and activate codes produce no issue pulse and no data window.
- R3: A column command sampled at clock edge n produces a one-clock `issue_pulse` visible after edge n+AL. `issue_wr` is 1 for a write and 0 for a read.
- R4: A read sampled at edge n raises `rd_valid` after edge n+AL+CL for two clocks. `rd_beat` is 0 in the first clock and 2 in the second.
- R5: A write sampled at edge n raises `wr_capture` after edge n+AL+CL-1 for two clocks. `wr_beat` is 0 in the first clock and 2 in the second.
- R6: Column commands of the same kind sent two clocks apart give one gapless window, and every read yields exactly two `rd_valid` clocks.
- R7: A write on `cfg_we` changes the latencies only when `cfg_al` is in 0..AL_MAX and `cfg_cl` is in CL_MIN..CL_MAX. Any other write leaves both latencies unchanged.
- R8: `trcd_err` is a one-clock pulse aligned with `issue_pulse`. It fires when the internal issue edge is fewer than TRCD edges after the last activate edge, or when no activate has been seen since reset.
- R9: Outside its window, each strobe output is low and its beat index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command code: 0 idle, 1 activate, 2 read, 3 write |
| cfg_we | input | 1 | Latency register write strobe |
| cfg_al | input | $clog2(AL_MAX+1) | Additive latency to program |
| cfg_cl | input | $clog2(CL_MAX+1) | CAS latency to program |
| issue_pulse | output | 1 | Column command issued internally this clock |
| issue_wr | output | 1 | Issued command is a write |
| rd_valid | output | 1 | Read data must be driven this clock |
| rd_beat | output | $clog2(BURST_BEATS) | Index of the first read beat of this clock |
| wr_capture | output | 1 | Write data must be captured this clock |
| wr_beat | output | $clog2(BURST_BEATS) | Index of the first write beat of this clock |
| trcd_err | output | 1 | Internal issue came too soon after the last activate |

## Verification
The bench builds the block with its defaults: AL_MAX 4, CL from 3 to 5, TRCD 3, and four-beat bursts at two beats per clock. The 3-bit latency fields can encode values past those limits, so rejected register writes can be driven directly. The programmed pairs reach both the shortest read latency (3) and the longest (9), which uses the far end of the delay line. With TRCD at 3, an activate followed at once by a read both passes (AL 2) and fails (AL 0) the activate-to-column check.

// File: rtl/pcas_pkg.sv
package pcas_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_RD   = 2'd2,
    CMD_WR   = 2'd3
  } pcas_cmd_e;

  // one delay-line slot: at most one of the two bits is set
  typedef struct packed {
    logic rd;
    logic wr;
  } col_slot_t;

endpackage

// File: rtl/pcas_cfg.sv
module pcas_cfg #(
  parameter int AL_MAX = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 5,
  parameter int AL_W   = $clog2(AL_MAX + 1),
  parameter int CL_W   = $clog2(CL_MAX + 1),
  parameter int LAT_W  = $clog2(AL_MAX + CL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AL_W-1:0]  cfg_al,
  input  logic [CL_W-1:0]  cfg_cl,
  output logic [AL_W-1:0]  al_q,
  output logic [CL_W-1:0]  cl_q,
  output logic [LAT_W-1:0] rl_q,
  output logic [LAT_W-1:0] wl_q
);

  logic in_range;

  assign in_range = (cfg_al <= AL_W'(AL_MAX)) &&
                    (cfg_cl >= CL_W'(CL_MIN)) &&
                    (cfg_cl <= CL_W'(CL_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q <= '0;
      cl_q <= CL_W'(CL_MIN);
      rl_q <= LAT_W'(CL_MIN);
      wl_q <= LAT_W'(CL_MIN - 1);
    end else if (cfg_we && in_range) begin
      al_q <= cfg_al;
      cl_q <= cfg_cl;
      rl_q <= LAT_W'(cfg_al) + LAT_W'(cfg_cl);
      wl_q <= LAT_W'(cfg_al) + LAT_W'(cfg_cl) - LAT_W'(1);
    end
  end

endmodule

// File: rtl/pcas_delay_line.sv
module pcas_delay_line
  import pcas_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  col_slot_t             slot_in,
  output col_slot_t [DEPTH:0]   taps
);

  col_slot_t stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= slot_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  // tap k = command sampled k edges before the coming edge
  always_comb begin
    taps[0] = slot_in;
    for (int i = 0; i < DEPTH; i++) begin
      taps[i+1] = stage[i];
    end
  end

endmodule

// File: rtl/pcas_strobe_gen.sv
module pcas_strobe_gen
  import pcas_pkg::*;
#(
  parameter int DEPTH         = 10,
  parameter int AL_W          = 3,
  parameter int LAT_W         = 4,
  parameter int BURST_CLKS    = 2,
  parameter int BEATS_PER_CLK = 2,
  parameter int BEAT_W        = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  col_slot_t [DEPTH:0]  taps,
  input  logic [AL_W-1:0]      al,
  input  logic [LAT_W-1:0]     rl,
  input  logic [LAT_W-1:0]     wl,
  output logic                 issue_now,
  output logic                 issue_pulse,
  output logic                 issue_wr,
  output logic                 rd_valid,
  output logic [BEAT_W-1:0]    rd_beat,
  output logic                 wr_capture,
  output logic [BEAT_W-1:0]    wr_beat
);

  localparam int IDX_W = $clog2(DEPTH + 1);

  function automatic col_slot_t pick(input col_slot_t [DEPTH:0] t, input int idx);
    logic [IDX_W-1:0] sel;
    sel = IDX_W'(idx);
    if (idx >= 0 && idx <= DEPTH) return t[sel];
    return '0;
  endfunction

  col_slot_t             iss_slot;
  logic                  rd_n, wr_n;
  logic [BEAT_W-1:0]     rdb_n, wrb_n;

  always_comb begin
    iss_slot = pick(taps, int'(al));
    rd_n  = 1'b0;
    wr_n  = 1'b0;
    rdb_n = '0;
    wrb_n = '0;
    for (int k = 0; k < BURST_CLKS; k++) begin
      if (!rd_n && pick(taps, int'(rl) + k).rd) begin
        rd_n  = 1'b1;
        rdb_n = BEAT_W'(k * BEATS_PER_CLK);
      end
      if (!wr_n && pick(taps, int'(wl) + k).wr) begin
        wr_n  = 1'b1;
        wrb_n = BEAT_W'(k * BEATS_PER_CLK);
      end
    end
  end

  assign issue_now = iss_slot.rd | iss_slot.wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_pulse <= 1'b0;
      issue_wr    <= 1'b0;
      rd_valid    <= 1'b0;
      rd_beat     <= '0;
      wr_capture  <= 1'b0;
      wr_beat     <= '0;
    end else begin
      issue_pulse <= issue_now;
      issue_wr    <= iss_slot.wr;
      rd_valid    <= rd_n;
      rd_beat     <= rdb_n;
      wr_capture  <= wr_n;
      wr_beat     <= wrb_n;
    end
  end

endmodule

// File: rtl/pcas_trcd_mon.sv
module pcas_trcd_mon #(
  parameter int TRCD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic act_in,
  input  logic issue_now,
  output logic trcd_err
);

  localparam int CNT_W = $clog2(TRCD + 1);

  logic [CNT_W-1:0] since_act;
  logic             act_seen;

  // since_act holds (edges since the activate edge) - 1 before each edge
  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '0;
      act_seen  <= 1'b0;
      trcd_err  <= 1'b0;
    end else begin
      if (act_in) begin
        since_act <= '0;
        act_seen  <= 1'b1;
      end else if (since_act != CNT_W'(TRCD)) begin
        since_act <= since_act + CNT_W'(1);
      end
      trcd_err <= issue_now && (!act_seen || since_act < CNT_W'(TRCD - 1));
    end
  end

endmodule

// File: rtl/pcas_sched.sv
module pcas_sched
  import pcas_pkg::*;
#(
  parameter int AL_MAX        = 4,
  parameter int CL_MIN        = 3,
  parameter int CL_MAX        = 5,
  parameter int TRCD          = 3,
  parameter int BURST_BEATS   = 4,
  parameter int BEATS_PER_CLK = 2,
  parameter int AL_W          = $clog2(AL_MAX + 1),
  parameter int CL_W          = $clog2(CL_MAX + 1),
  parameter int BEAT_W        = $clog2(BURST_BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd,
  input  logic              cfg_we,
  input  logic [AL_W-1:0]   cfg_al,
  input  logic [CL_W-1:0]   cfg_cl,
  output logic              issue_pulse,
  output logic              issue_wr,
  output logic              rd_valid,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              wr_capture,
  output logic [BEAT_W-1:0] wr_beat,
  output logic              trcd_err
);

  localparam int BURST_CLKS = BURST_BEATS / BEATS_PER_CLK;
  localparam int DEPTH      = AL_MAX + CL_MAX + BURST_CLKS - 1;
  localparam int LAT_W      = $clog2(AL_MAX + CL_MAX + 1);

  pcas_cmd_e             cmd_e;
  col_slot_t             slot_in;
  col_slot_t [DEPTH:0]   taps;
  logic [AL_W-1:0]       al_q;
  logic [CL_W-1:0]       cl_q;
  logic [LAT_W-1:0]      rl_q, wl_q;
  logic                  issue_now;

  assign cmd_e      = pcas_cmd_e'(cmd);
  assign slot_in.rd = (cmd_e == CMD_RD);
  assign slot_in.wr = (cmd_e == CMD_WR);

  pcas_cfg #(
    .AL_MAX(AL_MAX), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX),
    .AL_W(AL_W), .CL_W(CL_W), .LAT_W(LAT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
    .al_q(al_q), .cl_q(cl_q), .rl_q(rl_q), .wl_q(wl_q)
  );

  pcas_delay_line #(.DEPTH(DEPTH)) u_line (
    .clk(clk), .rst(rst), .slot_in(slot_in), .taps(taps)
  );

  pcas_strobe_gen #(
    .DEPTH(DEPTH), .AL_W(AL_W), .LAT_W(LAT_W), .BURST_CLKS(BURST_CLKS),
    .BEATS_PER_CLK(BEATS_PER_CLK), .BEAT_W(BEAT_W)
  ) u_strobe (
    .clk(clk), .rst(rst), .taps(taps), .al(al_q), .rl(rl_q), .wl(wl_q),
    .issue_now(issue_now), .issue_pulse(issue_pulse), .issue_wr(issue_wr),
    .rd_valid(rd_valid), .rd_beat(rd_beat),
    .wr_capture(wr_capture), .wr_beat(wr_beat)
  );

  pcas_trcd_mon #(.TRCD(TRCD)) u_trcd (
    .clk(clk), .rst(rst), .act_in(cmd_e == CMD_ACT),
    .issue_now(issue_now), .trcd_err(trcd_err)
  );

endmodule

// File: rtl/pcas_sched_chk.sv
module pcas_sched_chk #(
  parameter int AL_MAX = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 5,
  parameter int AL_W   = 3,
  parameter int CL_W   = 3,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cmd,
  input logic              cfg_we,
  input logic [AL_W-1:0]   cfg_al,
  input logic [CL_W-1:0]   cfg_cl,
  input logic              issue_pulse,
  input logic              issue_wr,
  input logic              rd_valid,
  input logic [BEAT_W-1:0] rd_beat,
  input logic              wr_capture,
  input logic [BEAT_W-1:0] wr_beat,
  input logic              trcd_err,
  input logic [AL_W-1:0]   al_q,
  input logic [CL_W-1:0]   cl_q
);

  logic cfg_bad;
  assign cfg_bad = (cfg_al > AL_W'(AL_MAX)) || (cfg_cl < CL_W'(CL_MIN)) ||
                   (cfg_cl > CL_W'(CL_MAX));

  // R3: with zero additive latency a read issues on the next clock as a read
  a_r3_rd_issue_al0: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd2 && al_q == '0) |=> (issue_pulse && !issue_wr));

  // R3: with zero additive latency a write issues on the next clock as a write
  a_r3_wr_issue_al0: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd3 && al_q == '0) |=> (issue_pulse && issue_wr));

  // R4: a read window that opens on beat 0 stays open one more clock
  a_r4_rd_two_clocks: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_beat == '0) |=> rd_valid);

  // R5: a write window that opens on beat 0 stays open one more clock
  a_r5_wr_two_clocks: assert property (@(posedge clk) disable iff (rst)
    (wr_capture && wr_beat == '0) |=> wr_capture);

  // R7: an out-of-range register write leaves both latencies alone
  a_r7_bad_cfg_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_bad) |=> ($stable(al_q) && $stable(cl_q)));

  // R7: latencies move only on a register write
  a_r7_cfg_needs_we: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(al_q) && $stable(cl_q)));

  // R8: the error pulse only accompanies an internal issue
  a_r8_err_on_issue: assert property (@(posedge clk) disable iff (rst)
    trcd_err |-> issue_pulse);

  // R9: idle windows report beat 0
  a_r9_rd_beat_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_beat == '0));

  a_r9_wr_beat_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_capture |-> (wr_beat == '0));

endmodule

bind pcas_sched pcas_sched_chk #(
  .AL_MAX(AL_MAX), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX),
  .AL_W(AL_W), .CL_W(CL_W), .BEAT_W(BEAT_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .cfg_we(cfg_we), .cfg_al(cfg_al),
  .cfg_cl(cfg_cl), .issue_pulse(issue_pulse), .issue_wr(issue_wr),
  .rd_valid(rd_valid), .rd_beat(rd_beat), .wr_capture(wr_capture),
  .wr_beat(wr_beat), .trcd_err(trcd_err), .al_q(al_q), .cl_q(cl_q)
);

// File: tb/pcas_sched_bench.sv
`timescale 1ns/1ps
module pcas_sched_bench;

  localparam int AL_MAX = 4;
  localparam int CL_MIN = 3;
  localparam int CL_MAX = 5;
  localparam int TRCD   = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd = 2'd0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_al = 3'd0;
  logic [2:0] cfg_cl = 3'd0;
  logic       issue_pulse, issue_wr, rd_valid, wr_capture, trcd_err;
  logic [1:0] rd_beat, wr_beat;

  always #2.5 clk = ~clk;

  pcas_sched #(.AL_MAX(AL_MAX), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .TRCD(TRCD))
    u_pcas_sched (
      .clk(clk), .rst(rst), .cmd(cmd), .cfg_we(cfg_we), .cfg_al(cfg_al),
      .cfg_cl(cfg_cl), .issue_pulse(issue_pulse), .issue_wr(issue_wr),
      .rd_valid(rd_valid), .rd_beat(rd_beat), .wr_capture(wr_capture),
      .wr_beat(wr_beat), .trcd_err(trcd_err)
    );

  typedef struct {
    int    at;
    int    kind;   // 0 issue, 1 read window, 2 write window
    bit    wr;
    bit    err;
    int    beat;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    checks = 0, fails = 0;
  int    b_al = 0, b_cl = CL_MIN;
  int    last_act = -1000;
  bit    act_seen = 0;
  bit    mon_on = 0;
  int    rd_hi = 0, exp_rd_hi = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic act_cmd();
    cmd = 2'd1;
    last_act = cyc + 1;
    act_seen = 1;
    @(negedge clk);
    cmd = 2'd0;
  endtask

  // driver: sends one column command and queues what it must produce
  task automatic col(input bit is_wr, input string tag);
    int c0, ic, w0;
    bit e;
    c0 = cyc + 1;
    ic = c0 + b_al;
    e  = !act_seen || (ic - last_act) < TRCD;
    w0 = is_wr ? ic + b_cl - 1 : ic + b_cl;
    cmd = is_wr ? 2'd3 : 2'd2;
    q.push_back('{ic, 0, is_wr, e, 0, tag});
    for (int k = 0; k < 2; k++) q.push_back('{w0 + k, is_wr ? 2 : 1, is_wr, 1'b0, 2 * k, tag});
    if (!is_wr) exp_rd_hi += 2;
    @(negedge clk);
    cmd = 2'd0;
  endtask

  task automatic set_cfg(input int a, input int c);
    cfg_we = 1'b1;
    cfg_al = 3'(a);
    cfg_cl = 3'(c);
    if (a <= AL_MAX && c >= CL_MIN && c <= CL_MAX) begin
      b_al = a;
      b_cl = c;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    idle(2);
  endtask

  // monitor: pops expected items and compares against the outputs
  int    now;
  bit    e_iss, e_isw, e_err, e_rd, e_wr;
  int    e_rdb, e_wrb;
  string t_iss, t_rd, t_wr;

  always @(negedge clk) begin
    if (mon_on) begin
      now = cyc;
      e_iss = 0; e_isw = 0; e_err = 0; e_rd = 0; e_wr = 0; e_rdb = 0; e_wrb = 0;
      t_iss = "R9"; t_rd = "R9"; t_wr = "R9";
      foreach (q[i]) begin
        if (q[i].at == now) begin
          case (q[i].kind)
            0: begin e_iss = 1; e_isw = q[i].wr; e_err = q[i].err; t_iss = q[i].tag; end
            1: begin e_rd = 1; e_rdb = q[i].beat; t_rd = q[i].tag; end
            default: begin e_wr = 1; e_wrb = q[i].beat; t_wr = q[i].tag; end
          endcase
        end
      end
      for (int i = q.size() - 1; i >= 0; i--) if (q[i].at <= now) q.delete(i);
      check(issue_pulse == e_iss, t_iss, "issue_pulse", int'(issue_pulse), int'(e_iss));
      if (e_iss) check(issue_wr == e_isw, "R3", "issue_wr", int'(issue_wr), int'(e_isw));
      check(trcd_err == e_err, "R8", "trcd_err", int'(trcd_err), int'(e_err));
      check(rd_valid == e_rd, t_rd, "rd_valid", int'(rd_valid), int'(e_rd));
      check(int'(rd_beat) == e_rdb, t_rd, "rd_beat", int'(rd_beat), e_rdb);
      check(wr_capture == e_wr, t_wr, "wr_capture", int'(wr_capture), int'(e_wr));
      check(int'(wr_beat) == e_wrb, t_wr, "wr_beat", int'(wr_beat), e_wrb);
      if (rd_valid) rd_hi++;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs held low during reset
    check({issue_pulse, issue_wr, rd_valid, wr_capture, trcd_err} == 5'b0 &&
          rd_beat == 2'd0 && wr_beat == 2'd0, "R1", "outputs in reset",
          int'({issue_pulse, issue_wr, rd_valid, wr_capture, trcd_err}), 0);
    rst = 1'b0;
    mon_on = 1;
    idle(2);
    // R1/R8: reset latencies (AL 0, CL 3) and no activate yet
    col(0, "R1");
    drain();
    // R4: plain read after the activate delay
    act_cmd();
    idle(2);
    col(0, "R4");
    drain();
    // R4/R5: early read right after activate with AL 2, then a write
    set_cfg(2, 3);
    act_cmd();
    col(0, "R4");
    idle(1);
    col(1, "R5");
    drain();
    // R7: out-of-range writes must not change the latencies
    set_cfg(5, 3);
    set_cfg(1, 6);
    set_cfg(2, 2);
    act_cmd();
    idle(3);
    col(0, "R7");
    idle(3);
    col(1, "R7");
    drain();
    // R6: longest latencies, seamless bursts
    set_cfg(4, 5);
    act_cmd();
    col(0, "R6"); idle(1);
    col(0, "R6"); idle(1);
    col(0, "R6"); idle(1);
    col(1, "R6"); idle(1);
    col(1, "R6"); idle(1);
    col(1, "R6");
    drain();
    // R8: zero AL, column command right after activate
    set_cfg(0, 3);
    act_cmd();
    col(0, "R8");
    idle(4);
    act_cmd();
    col(1, "R8");
    drain();
    // R2: activate alone yields nothing; write code after delay is legal
    act_cmd();
    idle(5);
    col(1, "R2");
    drain();
    mon_on = 0;
    check(rd_hi == exp_rd_hi, "R6", "rd_valid clock count", rd_hi, exp_rd_hi);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule